// File: doc/BRIEF.md
# Programmable Flag I/O with Dual Interrupt Routing

This block drives and samples sixteen general-purpose pins and turns activity on them into two interrupt requests. Each pin can be an output or an input. An input can be gated off, and it can be watched in one of two ways. In level mode the pin value, optionally inverted, is reflected directly into the flag register. In edge mode a latched flag is set by a rising edge, by a falling edge or by either edge.

All eight registers share one write port. The low two address bits select how the written data is applied: replace, OR-in, AND-out or XOR-in. Software therefore never needs a read-modify-write to change a single pin. Two independent mask registers pick which flags feed the higher-priority request and which feed the lower-priority one. A flag that software sets on an edge-mode input or an output pin asserts the routed request, which gives software-triggered interrupts.

Pins cross into the clock domain through a two-stage synchroniser. Reads are combinational from the register selected by the read address.

Top module: `flag_io_unit`

## Requirements
- R1: While reset is asserted and right after it, every register reads 0x0000, `pinOe` is 0 and both interrupt outputs are low.
- R2: Address bits [4:2] pick the register: 0 flag, 1 mask A, 2 mask B, 3 direction, 4 input enable, 5 edge select, 6 both-edge, 7 polarity. Address bits [1:0] pick the operation: 0 writes the data, 1 sets the bits that are 1 in the data, 2 clears them, 3 toggles them. `rdData` shows the register selected by `rdAddr[4:2]` in the same cycle.
- R3: `pinOe` equals the direction register (1 = output). `pinOut` carries the flag bit for output pins and 0 for input pins.
- R4: An input whose enable bit is 0 is seen as 0. Its level-mode flag is 0 and it produces no edges.
- R5: A pin change applied before rising edge k is reflected in the flag register after edge k+2 (two synchroniser stages plus the flag register).
- R6: For an input pin with edge select 0, the flag follows (pin XOR polarity) every cycle, with polarity 1 meaning active low. Software writes to such a flag bit have no effect after that cycle.
- R7: For an input pin with edge select 1 and both-edge 0, a rising edge sets the flag when polarity is 0 and a falling edge sets it when polarity is 1. The flag stays set until software clears it.
- R8: For an input pin with edge select 1 and both-edge 1, every edge sets the flag, whatever the polarity.
- R9: On an edge-mode input, an edge detected in the same cycle as a software clear of that flag bit leaves the flag set.
- R10: A software write that sets a flag bit of an output pin or of an edge-mode input holds, and it raises any interrupt whose mask enables that bit.
- R11: `irqA` is high exactly when some flag bit is set together with its mask A bit. `irqB` behaves the same way with mask B. The two outputs are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Write address: register index in [4:2], operation in [1:0] |
| wrData | input | 16 | Write data or bit mask |
| rdAddr | input | 5 | Read address, register index in [4:2] |
| rdData | output | 16 | Selected register contents |
| pinIn | input | 16 | Asynchronous pin inputs |
| pinOut | output | 16 | Pin output values |
| pinOe | output | 16 | Pin output enables |
| irqA | output | 1 | Higher-priority interrupt request |
| irqB | output | 1 | Lower-priority interrupt request |

## Verification
The bench drives a pin edge in the same cycle as a software clear of that flag; a design that lets the clear win would silently lose the event. It switches polarity while pins are held in level mode and in single-edge mode. Wrong polarity handling would show up as an inverted level flag, or as flags latched on the wrong edge. It also toggles input enables under moving pins, which exposes leakage of a disabled pin or a level flag that survives a software write. Long random runs of mixed write operations check that each set, clear and toggle alias touches only the selected bits, and that the two interrupt outputs never follow each other's mask.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int REG_CNT = 8;
  localparam int SEL_W   = $clog2(REG_CNT);
  localparam int ADDR_W  = SEL_W + 2;

  localparam int IDX_FLAG  = 0;
  localparam int IDX_MASKA = 1;
  localparam int IDX_MASKB = 2;
  localparam int IDX_DIR   = 3;
  localparam int IDX_INEN  = 4;
  localparam int IDX_EDGE  = 5;
  localparam int IDX_BOTH  = 6;
  localparam int IDX_POL   = 7;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } regOp_e;

  typedef struct packed {
    logic [REG_CNT-1:0] load;
    logic [REG_CNT-1:0] set;
    logic [REG_CNT-1:0] clr;
    logic [REG_CNT-1:0] tgl;
  } flagStb_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output flagStb_t          stb,
  output logic [SEL_W-1:0]  rdSel
);
  logic [SEL_W-1:0] wrSel;
  regOp_e           wrOp;

  assign wrSel = wrAddr[ADDR_W-1:2];
  assign wrOp  = regOp_e'(wrAddr[1:0]);
  assign rdSel = rdAddr[ADDR_W-1:2];

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (wrOp)
        OP_WRITE:  stb.load[wrSel] = 1'b1;
        OP_SET:    stb.set[wrSel]  = 1'b1;
        OP_CLEAR:  stb.clr[wrSel]  = 1'b1;
        OP_TOGGLE: stb.tgl[wrSel]  = 1'b1;
        default:   stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  flagStb_t         stb,
  input  logic [W-1:0]     wrData,
  input  logic [SEL_W-1:0] rdSel,
  input  logic [W-1:0]     pinIn,
  output logic [W-1:0]     rdData,
  output logic [W-1:0]     pinOut,
  output logic [W-1:0]     pinOe,
  output logic             irqA,
  output logic             irqB
);
  logic [W-1:0] regQ   [REG_CNT];
  logic [W-1:0] swNext [REG_CNT];
  logic [W-1:0] regNext[REG_CNT];
  logic [W-1:0] syncQ  [SYNC_STAGES];
  logic [W-1:0] prevQ;

  logic [W-1:0] flagQ, dirQ, inEnQ, edgeQ, bothQ, polQ;
  logic [W-1:0] inVal, levelVal, levelSel, edgeSel, evt, flagNext;

  assign flagQ = regQ[IDX_FLAG];
  assign dirQ  = regQ[IDX_DIR];
  assign inEnQ = regQ[IDX_INEN];
  assign edgeQ = regQ[IDX_EDGE];
  assign bothQ = regQ[IDX_BOTH];
  assign polQ  = regQ[IDX_POL];

  // software update of every register through its four aliases
  always_comb begin
    for (int r = 0; r < REG_CNT; r++) begin
      if (stb.load[r])      swNext[r] = wrData;
      else if (stb.set[r])  swNext[r] = regQ[r] | wrData;
      else if (stb.clr[r])  swNext[r] = regQ[r] & ~wrData;
      else if (stb.tgl[r])  swNext[r] = regQ[r] ^ wrData;
      else                  swNext[r] = regQ[r];
    end
  end

  // input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= inVal;
    end
  end

  assign inVal    = syncQ[SYNC_STAGES-1] & inEnQ;
  assign levelVal = inEnQ & (syncQ[SYNC_STAGES-1] ^ polQ);
  assign levelSel = ~dirQ & ~edgeQ;
  assign edgeSel  = ~dirQ & edgeQ;

  // per-pin edge detector
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_edge
      logic rise, fall;
      assign rise   = inVal[b] & ~prevQ[b];
      assign fall   = ~inVal[b] & prevQ[b];
      assign evt[b] = bothQ[b] ? (rise | fall) : (polQ[b] ? fall : rise);
    end
  endgenerate

  assign flagNext = (levelSel & levelVal)
                  | (~levelSel & (swNext[IDX_FLAG] | (edgeSel & evt)));

  always_comb begin
    for (int r = 0; r < REG_CNT; r++) regNext[r] = swNext[r];
    regNext[IDX_FLAG] = flagNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < REG_CNT; r++) regQ[r] <= '0;
    end else begin
      for (int r = 0; r < REG_CNT; r++) regQ[r] <= regNext[r];
    end
  end

  assign rdData = regQ[rdSel];
  assign pinOe  = dirQ;
  assign pinOut = flagQ & dirQ;
  assign irqA   = |(flagQ & regQ[IDX_MASKA]);
  assign irqB   = |(flagQ & regQ[IDX_MASKB]);
endmodule

// File: rtl/flag_io_unit.sv
module flag_io_unit
  import flag_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [W-1:0]      wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [W-1:0]      rdData,
  input  logic [W-1:0]      pinIn,
  output logic [W-1:0]      pinOut,
  output logic [W-1:0]      pinOe,
  output logic              irqA,
  output logic              irqB
);
  flagStb_t         stb;
  logic [SEL_W-1:0] rdSel;

  flag_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  flag_datapath #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .rdSel  (rdSel),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqA   (irqA),
    .irqB   (irqB)
  );
endmodule

// File: rtl/flag_io_chk.sv
module flag_io_chk
  import flag_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [W-1:0]      wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [W-1:0]      rdData,
  input logic [W-1:0]      pinOe,
  input logic              irqA,
  input logic              irqB
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (pinOe == '0 && !irqA && !irqB));

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr[ADDR_W-1:2] == SEL_W'(IDX_DIR)) |=> $stable(pinOe));

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(IDX_DIR * 4)) |=> pinOe == $past(wrData));

  // R11
  irqa_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr[ADDR_W-1:2] == SEL_W'(IDX_MASKA) && rdData == '0) |-> !irqA);

  // R11
  irqb_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr[ADDR_W-1:2] == SEL_W'(IDX_MASKB) && rdData == '0) |-> !irqB);
endmodule

bind flag_io_unit flag_io_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .rdAddr (rdAddr),
  .rdData (rdData),
  .pinOe  (pinOe),
  .irqA   (irqA),
  .irqB   (irqB)
);

// File: tb/tb_flag_io_unit.sv
`timescale 1ns/1ps
module tb_flag_io_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [4:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut, pinOe;
  logic        irqA, irqB;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  bit    started = 0;
  string phaseReq = "R1";

  always #5 clk = ~clk;

  flag_io_unit dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqA(irqA), .irqB(irqB)
  );

  // behavioural reference model
  logic [15:0] m [8];
  logic [15:0] ms0, ms1, mprev;

  always @(posedge clk) begin
    logic [15:0] o [8];
    logic [15:0] sw, nf;
    logic inv, rise, fall, hit;
    int idx;
    if (!rstN) begin
      for (int i = 0; i < 8; i++) m[i] = '0;
      ms0 = '0; ms1 = '0; mprev = '0;
    end else begin
      for (int i = 0; i < 8; i++) o[i] = m[i];
      if (wrEn) begin
        idx = int'(wrAddr[4:2]);
        case (wrAddr[1:0])
          2'd0: m[idx] = wrData;
          2'd1: m[idx] = o[idx] | wrData;
          2'd2: m[idx] = o[idx] & ~wrData;
          default: m[idx] = o[idx] ^ wrData;
        endcase
      end
      sw = m[0];
      for (int bt = 0; bt < 16; bt++) begin
        inv = ms1[bt] & o[4][bt];
        if (!o[3][bt] && !o[5][bt]) begin
          nf[bt] = o[4][bt] & (ms1[bt] ^ o[7][bt]);
        end else begin
          nf[bt] = sw[bt];
          if (!o[3][bt]) begin
            rise = inv & !mprev[bt];
            fall = !inv & mprev[bt];
            hit = o[6][bt] ? (rise | fall) : (o[7][bt] ? fall : rise);
            if (hit) nf[bt] = 1'b1;
          end
        end
        mprev[bt] = inv;
      end
      m[0] = nf;
      ms1 = ms0;
      ms0 = pinIn;
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #4;
    if (started && !done) begin
      logic ea, eb;
      ea = |(m[0] & m[1]);
      eb = |(m[0] & m[2]);
      check(phaseReq, "rdData", rdData, m[rdAddr[4:2]]);
      check("R3", "pinOe", pinOe, m[3]);
      check("R3", "pinOut", pinOut, m[0] & m[3]);
      check("R11", "irqA", {15'd0, irqA}, {15'd0, ea});
      check("R11", "irqB", {15'd0, irqB}, {15'd0, eb});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic [15:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  initial begin
    // R1: reset state, read every register
    started = 1;
    phaseReq = "R1";
    repeat (3) @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      rdAddr = 5'(r * 4);
      @(negedge clk);
    end
    rstN = 1'b1;
    for (int r = 0; r < 8; r++) begin
      rdAddr = 5'(r * 4);
      @(negedge clk);
    end

    // R2: aliases on mask A
    phaseReq = "R2";
    rdAddr = 5'd4;
    wr(5'd4, 16'h1234);
    wr(5'd5, 16'h8001);
    wr(5'd6, 16'h0204);
    wr(5'd7, 16'hFF00);
    idle(2);

    // R3: direction and output data
    phaseReq = "R3";
    rdAddr = 5'd0;
    wr(5'd12, 16'h00FF);
    wr(5'd0, 16'hA5A5);
    idle(2);
    wr(5'd3, 16'h000F);
    idle(2);

    // R4: disabled inputs read as 0
    phaseReq = "R4";
    wr(5'd28, 16'hFF00);
    pins(16'hF0F0); idle(4);
    pins(16'h0F0F); idle(4);

    // R5 / R6: level mode with polarity
    phaseReq = "R5";
    wr(5'd16, 16'hFFFF);
    pins(16'h0F00); idle(1);
    pins(16'hFF00); idle(4);
    phaseReq = "R6";
    wr(5'd28, 16'h0300);
    idle(3);
    wr(5'd1, 16'hFF00);
    idle(3);
    pins(16'h3000); idle(4);

    // R7: single-edge latch and clear
    phaseReq = "R7";
    wr(5'd28, 16'h0000);
    wr(5'd20, 16'hFF00);
    wr(5'd28, 16'h0F00);
    pins(16'h0000); idle(4);
    pins(16'hFF00); idle(4);
    pins(16'h0000); idle(4);
    wr(5'd2, 16'hFF00);
    idle(2);
    pins(16'hFF00); idle(4);
    wr(5'd2, 16'hFF00);

    // R8: both edges
    phaseReq = "R8";
    wr(5'd24, 16'hF000);
    pins(16'h0000); idle(4);
    wr(5'd2, 16'hFF00);
    pins(16'hFFFF); idle(4);

    // R9: edge in the same cycle as a clear
    phaseReq = "R9";
    wr(5'd2, 16'hFFFF);
    pins(16'h0000); idle(1);
    wr(5'd2, 16'hFFFF);
    idle(3);

    // R10 / R11: software interrupts through both masks
    phaseReq = "R10";
    wr(5'd4, 16'h0000);
    wr(5'd8, 16'h0000);
    wr(5'd2, 16'hFFFF);
    wr(5'd5, 16'h1000);
    wr(5'd9, 16'h0001);
    wr(5'd1, 16'h1000);
    idle(2);
    wr(5'd1, 16'h0001);
    idle(2);
    phaseReq = "R11";
    wr(5'd6, 16'h1000);
    idle(2);
    wr(5'd2, 16'h0001);
    idle(2);

    // random mixed traffic
    phaseReq = "R2";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wrEn   = ($urandom_range(0, 3) == 0);
      wrAddr = 5'($urandom);
      wrData = 16'($urandom);
      rdAddr = 5'($urandom);
      if ($urandom_range(0, 2) == 0) pinIn = pinIn ^ 16'($urandom);
    end
    @(negedge clk);
    wrEn = 1'b0;
    idle(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule